// File: doc/BRIEF.md
# Prioritized Bus Interrupt Request Generator

This block lets software raise one of seven prioritized interrupt request lines on a shared system bus. Software writes a nonzero level into a control word, and the matching request line goes active. The line stays active until an interrupt handler acknowledges that same level, or until software withdraws the request through a clear bit. A status bit shows whether the raised interrupt is still waiting for acknowledgement. An 8-bit vector register holds the status/ID byte that the acknowledge logic elsewhere presents during the acknowledge cycle. This block only outputs that byte.

Request line 1 can also carry a periodic broadcast signal. A 2-bit source select routes either the block's own level-1 request or one of two tick-timer inputs onto that line.

All state sits in one register word. A write updates the select and vector fields. It also carries one-shot level and clear commands. Reads return the select field, the vector, the pending status, and zeros in the command fields.

Top module: `prio_irq_source`

## Requirements
- R1: After reset no request line is active, the status bit (read bit 4) is 0, the source select (read bits 6:5) is 0 and the vector (read bits 15:8 and `vector`) is 0x0F.
- R2: While nothing is pending, a write whose level field (write bits 2:0) holds a nonzero value L and whose clear bit (bit 3) is 0 activates only request line L (`irq_req[L-1]`) from the next cycle on, and sets the status bit to 1.
- R3: A write with level field 0 raises nothing, and the level field always reads as 0.
- R4: An acknowledge (`ack_valid` high) whose `ack_level` equals the pending level drops the request and the status bit on the next cycle. An acknowledge of any other level leaves both unchanged.
- R5: A level write made while an interrupt is pending is ignored: the active line and the status bit do not change.
- R6: Writing 1 to the clear bit (bit 3) withdraws any pending request on the next cycle. It wins over a level in the same write, and the bit always reads as 0.
- R7: Request line 1 (`irq_req[0]`) follows the source select (bits 6:5): codes 0 and 2 give the block's own level-1 request, code 1 gives `tick1` and code 3 gives `tick2`.
- R8: The vector field (write bits 15:8) can be written at any time, is shown on `vector`, and reads back unchanged.
- R9: At most one of request lines 2 to 7 is active at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write word |
| rd_data | output | 16 | Register read word |
| irq_req | output | 7 | Active-high request lines; bit i is level i+1 |
| ack_valid | input | 1 | Acknowledge cycle in progress |
| ack_level | input | 3 | Level being acknowledged |
| tick1 | input | 1 | First tick-timer output |
| tick2 | input | 1 | Second tick-timer output |
| vector | output | 8 | Status/ID byte for the acknowledge cycle |

## Verification
The assertions check the following on every cycle:
- Lines 2 to 7 are one-hot or idle.
- A nonzero write raises the pending state with that level, and a zero write raises nothing.
- A pending interrupt keeps its level until a matching acknowledge or a clear, and either of those ends it.

Only the bench's scenarios can show what reaches the ports:
- the mapping from a written level to the exact output line;
- that mismatched acknowledges have no effect;
- the routing of line 1 under each select code and tick combination;
- the readback of the vector and of the fields that always read as zero.

// File: rtl/prio_irq_source.sv
module prio_irq_source #(
  parameter int          LVL_W     = 3,
  parameter int          VEC_W     = 8,
  parameter logic [7:0]  VEC_RESET = 8'h0F
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [15:0]                wr_data,
  output logic [15:0]                rd_data,
  output logic [(1<<LVL_W)-2:0]      irq_req,
  input  logic                       ack_valid,
  input  logic [LVL_W-1:0]           ack_level,
  input  logic                       tick1,
  input  logic                       tick2,
  output logic [VEC_W-1:0]           vector
);
  localparam int NLINES = (1 << LVL_W) - 1;

  logic             pending;
  logic [LVL_W-1:0] level;
  logic [1:0]       sel;
  logic [VEC_W-1:0] vec;
  logic [NLINES-1:0] own_req;

  wire [LVL_W-1:0] wr_lvl = wr_data[LVL_W-1:0];
  wire             wr_clr = wr_data[3];
  wire             ack_hit = pending && ack_valid && (ack_level == level);
  wire             clr_hit = wr_en && wr_clr;
  wire             raise   = wr_en && !wr_clr && !pending && (wr_lvl != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      level   <= '0;
      sel     <= 2'd0;
      vec     <= VEC_RESET[VEC_W-1:0];
    end else begin
      if (wr_en) begin
        sel <= wr_data[6:5];
        vec <= wr_data[8 +: VEC_W];
      end
      if (clr_hit || ack_hit) begin
        pending <= 1'b0;
      end else if (raise) begin
        pending <= 1'b1;
        level   <= wr_lvl;
      end
    end
  end

  always_comb begin
    own_req = '0;
    for (int i = 1; i <= NLINES; i++)
      if (pending && level == LVL_W'(i)) own_req[i-1] = 1'b1;
  end

  always_comb begin
    irq_req = own_req;
    case (sel)
      2'd1:    irq_req[0] = tick1;
      2'd3:    irq_req[0] = tick2;
      default: irq_req[0] = own_req[0];
    endcase
  end

  assign vector  = vec;
  assign rd_data = {vec, 1'b0, sel, pending, 4'b0000};

  AST_UPPER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_req[NLINES-1:1])); // R9
  AST_RAISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && wr_en && !wr_data[3] && wr_data[LVL_W-1:0] != '0) |=>
      (pending && level == $past(wr_data[LVL_W-1:0]))); // R2
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && wr_en && wr_data[LVL_W-1:0] == '0) |=> !pending); // R3
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && ack_valid && ack_level == level) |=> !pending); // R4
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !(ack_valid && ack_level == level) && !(wr_en && wr_data[3])) |=>
      (pending && $stable(level))); // R5
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3]) |=> !pending); // R6
endmodule

// File: tb/prio_irq_source_test.sv
module prio_irq_source_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [6:0]  irq_req;
  logic        ack_valid = 1'b0;
  logic [2:0]  ack_level = '0;
  logic        tick1 = 1'b0, tick2 = 1'b0;
  logic [7:0]  vector;

  int total = 0, failed = 0;
  logic [7:0] cur_vec = 8'h0F;
  logic [1:0] cur_sel = 2'd0;

  always #2 clk = ~clk;

  prio_irq_source uut (.clk, .rst_n, .wr_en, .wr_data, .rd_data, .irq_req,
    .ack_valid, .ack_level, .tick1, .tick2, .vector);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] lvl, input logic clr);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {cur_vec, 1'b0, cur_sel, 1'b0, clr, lvl};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ack(input logic [2:0] lvl);
    @(negedge clk);
    ack_valid = 1'b1; ack_level = lvl;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  function automatic logic [6:0] line(input int l);
    return (l == 0) ? 7'd0 : 7'(1 << (l - 1));
  endfunction

  initial begin
    #200000;
    failed++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lines", irq_req, 0);
    chk("R1 readback", rd_data, 16'h0F00);
    chk("R1 vector", vector, 8'h0F);

    for (int l = 1; l <= 7; l++) begin
      wr(3'(l), 1'b0);
      chk("R2 line", irq_req, line(l));
      chk("R2 status", rd_data[4], 1);
      chk("R3 level reads zero", rd_data[2:0], 0);
      for (int a = 0; a <= 7; a++) if (a != l) begin
        ack(3'(a));
        chk("R4 mismatched ack", irq_req, line(l));
      end
      for (int m = 1; m <= 7; m++) if (m != l) begin
        wr(3'(m), 1'b0);
        chk("R5 ignored write", irq_req, line(l));
        chk("R5 status", rd_data[4], 1);
      end
      ack(3'(l));
      chk("R4 ack drops", irq_req, 0);
      chk("R4 status drops", rd_data[4], 0);
    end

    wr(3'd0, 1'b0);
    chk("R3 zero write", irq_req, 0);
    chk("R3 zero status", rd_data[4], 0);

    for (int l = 1; l <= 7; l++) begin
      wr(3'(l), 1'b0);
      wr(3'd0, 1'b1);
      chk("R6 clear", irq_req, 0);
      chk("R6 clear reads zero", rd_data[3], 0);
      wr(3'(l), 1'b1);
      chk("R6 clear wins", irq_req, 0);
      chk("R6 status", rd_data[4], 0);
    end

    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        cur_sel = 2'(s);
        wr(3'd0, 1'b1);
        if (p == 1) wr(3'd1, 1'b0);
        chk("R7 select readback", rd_data[6:5], s);
        for (int t = 0; t < 4; t++) begin
          tick1 = t[0]; tick2 = t[1];
          #1;
          chk("R7 line1", irq_req[0],
              (s == 1) ? t[0] : (s == 3) ? t[1] : p[0]);
          chk("R7 upper quiet", irq_req[6:1], 0);
        end
      end
    end
    tick1 = 0; tick2 = 0; cur_sel = 0;
    wr(3'd0, 1'b1);

    for (int v = 0; v < 256; v += 37) begin
      cur_vec = 8'(v);
      wr(3'd0, 1'b0);
      chk("R8 vector out", vector, v);
      chk("R8 readback", rd_data[15:8], v);
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule